// File: doc/BRIEF.md
# Page Write Load and Program Controller

This block manages the two phases of a paged nonvolatile write. In the load phase it takes byte writes into a page buffer of 2^OFS_W slots (128 by default). Each write carries a full byte address. The upper address bits name the page row and the low OFS_W bits pick the slot. A bitmap records which slots were touched. Bytes may come in any order, and a slot written twice keeps its newest value.

The load phase closes by itself once no byte has been stored for LOAD_TIMEOUT clock cycles. The block then enters a programming period of PROG_CYCLES cycles. On the final cycle of that period it presents the row, the bitmap and the buffered bytes to the array for exactly one cycle. Only slots whose bitmap bit is set are to be written.

Write events use a valid/ready handshake. `wr_ready` is low for the whole programming period. A source may keep `wr_valid` asserted and wait, or withdraw it. Nothing is stored unless `wr_valid` and `wr_ready` are both high at a clock edge. While loading, every write is accepted. A write whose row differs from the captured row is accepted and thrown away. The most recently stored byte and its slot are always visible so that a host can poll.

Top module: `page_write_ctrl`

## Requirements
- R1: `wr_ready` is low exactly while `busy` is high. A write presented then is not taken and changes neither the buffer, the bitmap nor the last-byte outputs.
- R2: The first write taken while idle (neither `loading` nor `busy`) is stored. `row_addr` then shows its address bits [ADDR_W-1:OFS_W], and `loading` is high from the next cycle.
- R3: Address bits [OFS_W-1:0] select the slot. Slots may be filled in any order, and a slot written again in the same load keeps the later byte.
- R4: While loading, a taken write whose row bits differ from `row_addr` is discarded. It changes no slot, no bitmap bit and no last-byte output, and it does not restart the inactivity count.
- R5: Loading ends, and `busy` rises, at the LOAD_TIMEOUT-th clock edge after the edge that stored the last byte, provided no matching byte was stored in between.
- R6: A matching byte stored after a gap of LOAD_TIMEOUT-1 empty cycles keeps the load open and restarts the count.
- R7: `busy` stays high for exactly PROG_CYCLES cycles. `commit_valid` is high for exactly one cycle, the last busy cycle.
- R8: While `commit_valid` is high, `commit_mask` bit i is 1 exactly when slot i was stored during this load, and `commit_data[DATA_W*i +: DATA_W]` holds that slot's byte.
- R9: `last_data` and `last_ofs` show the byte and slot of the most recent stored write.
- R10: After reset the block is idle. `busy` and `loading` are 0, `wr_ready` is 1, `commit_valid` is 0 and `commit_mask` is all zero.
- R11: The bitmap is all zero in the cycle after `commit_valid`, so the next load commits only its own slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write event present |
| wr_ready | output | 1 | Write event can be taken |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Byte to write |
| busy | output | 1 | Programming period in progress |
| loading | output | 1 | Load phase open |
| row_addr | output | ADDR_W-OFS_W | Row captured from the first write of the load |
| commit_valid | output | 1 | One-cycle strobe to program the array |
| commit_mask | output | 2^OFS_W | Slots stored during the load |
| commit_data | output | DATA_W*2^OFS_W | Page buffer contents, slot i at bits DATA_W*i upward |
| last_data | output | DATA_W | Most recently stored byte |
| last_ofs | output | OFS_W | Slot of the most recently stored byte |

## Verification
The hardest cases to reach are the edges of the inactivity window. One is a matching byte that lands exactly when the count would expire. The other is a wrong-row write that lands in the final window cycle, which must not stretch it. The stimulus spaces bytes with gaps of exactly LOAD_TIMEOUT-1 idle cycles. It also places a wrong-row write just before expiry. It then holds a write valid across a whole programming period, so that the write is taken on the first cycle after `busy` falls. A randomized stretch over two rows then mixes these cases, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_LOAD = 2'd1,
    PW_PROG = 2'd2
  } pw_state_t;
endpackage

// File: rtl/pwc_interval.sv
// Cycle counter: hit is high on the LIMIT-th running cycle after a clear.
module pwc_interval #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic hit
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign hit = run && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clear)      cnt_q <= '0;
    else if (run && !hit) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwc_page_buf.sv
// Page buffer: one byte register and one loaded flag per slot.
module pwc_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [OFS_W-1:0]               ofs,
  input  logic [DATA_W-1:0]              din,
  input  logic                           clr,
  output logic [(1<<OFS_W)-1:0]          mask,
  output logic [DATA_W*(1<<OFS_W)-1:0]   data
);
  localparam int PAGE = 1 << OFS_W;

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    logic [DATA_W-1:0] byte_q;
    logic              used_q;
    logic              sel;

    assign sel = we && (ofs == OFS_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        byte_q <= '0;
        used_q <= 1'b0;
      end else if (sel) begin
        byte_q <= din;
        used_q <= 1'b1;
      end else if (clr) begin
        used_q <= 1'b0;
      end
    end

    assign mask[g]                   = used_q;
    assign data[g*DATA_W +: DATA_W]  = byte_q;
  end
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pwc_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 8,
  parameter int OFS_W        = 7,
  parameter int LOAD_TIMEOUT = 7500,
  parameter int PROG_CYCLES  = 500000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_valid,
  output logic                              wr_ready,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic                              busy,
  output logic                              loading,
  output logic [ADDR_W-OFS_W-1:0]           row_addr,
  output logic                              commit_valid,
  output logic [(1<<OFS_W)-1:0]             commit_mask,
  output logic [DATA_W*(1<<OFS_W)-1:0]      commit_data,
  output logic [DATA_W-1:0]                 last_data,
  output logic [OFS_W-1:0]                  last_ofs
);
  localparam int ROW_W = ADDR_W - OFS_W;

  pw_state_t        st_q, st_d;
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] in_row;
  logic [OFS_W-1:0] in_ofs;
  logic             accept, store, to_hit, pg_hit, enter_prog;

  assign in_row = wr_addr[ADDR_W-1:OFS_W];
  assign in_ofs = wr_addr[OFS_W-1:0];

  assign wr_ready = (st_q != PW_PROG);
  assign accept   = wr_valid && wr_ready;
  assign store    = accept && ((st_q == PW_IDLE) || (in_row == row_q));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PW_IDLE: if (store)            st_d = PW_LOAD;
      PW_LOAD: if (!store && to_hit) st_d = PW_PROG;
      PW_PROG: if (pg_hit)           st_d = PW_IDLE;
      default:                       st_d = PW_IDLE;
    endcase
  end

  assign enter_prog = (st_q == PW_LOAD) && (st_d == PW_PROG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= PW_IDLE;
      row_q     <= '0;
      last_data <= '0;
      last_ofs  <= '0;
    end else begin
      st_q <= st_d;
      if (store && st_q == PW_IDLE) row_q <= in_row;
      if (store) begin
        last_data <= wr_data;
        last_ofs  <= in_ofs;
      end
    end
  end

  pwc_interval #(.LIMIT(LOAD_TIMEOUT)) u_load_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (store),
    .run   (st_q == PW_LOAD),
    .hit   (to_hit)
  );

  pwc_interval #(.LIMIT(PROG_CYCLES)) u_prog_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (enter_prog),
    .run   (st_q == PW_PROG),
    .hit   (pg_hit)
  );

  pwc_page_buf #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store),
    .ofs   (in_ofs),
    .din   (wr_data),
    .clr   (pg_hit),
    .mask  (commit_mask),
    .data  (commit_data)
  );

  assign busy         = (st_q == PW_PROG);
  assign loading      = (st_q == PW_LOAD);
  assign row_addr     = row_q;
  assign commit_valid = pg_hit;
endmodule

// File: rtl/pwc_chk.sv
module pwc_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int OFS_W  = 7
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_valid,
  input logic                        wr_ready,
  input logic [ADDR_W-1:0]           wr_addr,
  input logic                        busy,
  input logic                        loading,
  input logic [ADDR_W-OFS_W-1:0]     row_addr,
  input logic                        commit_valid,
  input logic [(1<<OFS_W)-1:0]       commit_mask,
  input logic [DATA_W-1:0]           last_data,
  input logic [OFS_W-1:0]            last_ofs
);
  logic [ADDR_W-OFS_W-1:0] w_row;
  logic [OFS_W-1:0]        w_ofs;
  assign w_row = wr_addr[ADDR_W-1:OFS_W];
  assign w_ofs = wr_addr[OFS_W-1:0];

  // R1
  held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(last_data) && $stable(last_ofs));

  // R2
  first_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loading && !busy && wr_valid) |=> loading && row_addr == $past(w_row));

  // R4
  drop_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && wr_valid && w_row != row_addr) |=> $stable(commit_mask) && $stable(last_ofs));

  // R5
  busy_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(loading));

  // R7
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> busy ##1 (!commit_valid && !busy));

  // R8
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && wr_valid && w_row == row_addr) |=> commit_mask[$past(w_ofs)]);

  // R11
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> commit_mask == '0);
endmodule

bind page_write_ctrl pwc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_pwc_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .busy         (busy),
  .loading      (loading),
  .row_addr     (row_addr),
  .commit_valid (commit_valid),
  .commit_mask  (commit_mask),
  .last_data    (last_data),
  .last_ofs     (last_ofs)
);

// File: tb/test_page_write_ctrl.sv
module test_page_write_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 19;
  localparam int DW   = 8;
  localparam int OW   = 7;
  localparam int TO   = 5;
  localparam int PC   = 8;
  localparam int PAGE = 1 << OW;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 wr_valid = 1'b0;
  logic                 wr_ready;
  logic [AW-1:0]        wr_addr = '0;
  logic [DW-1:0]        wr_data = '0;
  logic                 busy, loading, commit_valid;
  logic [AW-OW-1:0]     row_addr;
  logic [PAGE-1:0]      commit_mask;
  logic [DW*PAGE-1:0]   commit_data;
  logic [DW-1:0]        last_data;
  logic [OW-1:0]        last_ofs;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  page_write_ctrl #(.ADDR_W(AW), .DATA_W(DW), .OFS_W(OW),
                    .LOAD_TIMEOUT(TO), .PROG_CYCLES(PC)) i_page_write_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .loading(loading),
    .row_addr(row_addr), .commit_valid(commit_valid), .commit_mask(commit_mask),
    .commit_data(commit_data), .last_data(last_data), .last_ofs(last_ofs));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: 0 idle, 1 loading, 2 programming
  int       m_st, m_gap, m_pc, m_row, m_last_d, m_last_o;
  bit       m_used [PAGE];
  int       m_byte [PAGE];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_gap = 0; m_pc = 0; m_row = 0; m_last_d = 0; m_last_o = 0;
      for (int i = 0; i < PAGE; i++) begin m_used[i] = 0; m_byte[i] = 0; end
    end else begin
      int r, o;
      bit take, keep;
      r = int'(wr_addr >> OW);
      o = int'(wr_addr) % PAGE;
      take = wr_valid && (m_st != 2);
      keep = take && (m_st == 0 || r == m_row);
      if (keep) begin
        m_used[o] = 1; m_byte[o] = int'(wr_data);
        m_last_d = int'(wr_data); m_last_o = o;
      end
      if (m_st == 0) begin
        if (keep) begin m_row = r; m_st = 1; m_gap = 0; end
      end else if (m_st == 1) begin
        if (keep) m_gap = 0;
        else if (m_gap == TO - 1) begin m_st = 2; m_pc = 0; end
        else m_gap++;
      end else begin
        if (m_pc == PC - 1) begin
          m_st = 0;
          for (int i = 0; i < PAGE; i++) m_used[i] = 0;
        end else m_pc++;
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit m_commit;
      m_commit = (m_st == 2) && (m_pc == PC - 1);
      chk("R1 wr_ready", longint'(wr_ready), longint'(m_st != 2));
      chk("R7 busy", longint'(busy), longint'(m_st == 2));
      chk("R5 loading", longint'(loading), longint'(m_st == 1));
      chk("R7 commit_valid", longint'(commit_valid), longint'(m_commit));
      chk("R9 last_data", longint'(last_data), longint'(m_last_d));
      chk("R9 last_ofs", longint'(last_ofs), longint'(m_last_o));
      if (m_st != 0) chk("R2 row_addr", longint'(row_addr), longint'(m_row));
      begin
        int bad_m, bad_d;
        bad_m = -1; bad_d = -1;
        for (int i = 0; i < PAGE; i++) begin
          if (commit_mask[i] !== m_used[i] && bad_m < 0) bad_m = i;
          if (m_used[i] && int'(commit_data[i*DW +: DW]) != m_byte[i] && bad_d < 0) bad_d = i;
        end
        chk("R11 commit_mask slot", longint'(bad_m), -1);
        if (m_commit) chk("R8 R3 commit_data slot", longint'(bad_d), -1);
      end
    end
  end

  task automatic put(int row, int ofs, int d, int gap);
    wr_addr  = AW'((row << OW) | ofs);
    wr_data  = DW'(d);
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 busy", longint'(busy), 0);
    chk("R10 loading", longint'(loading), 0);
    chk("R10 wr_ready", longint'(wr_ready), 1);
    chk("R10 commit_valid", longint'(commit_valid), 0);
    chk("R10 commit_mask", longint'(commit_mask == '0), 1);

    // Single byte load (R2, R5, R7)
    put(5, 3, 8'hA5, 25);

    // Out-of-order fill with overwrite, gaps of TO-1 keep the load (R3, R6)
    put(9, 100, 8'h11, TO - 1);
    put(9, 2,   8'h22, TO - 1);
    put(9, 100, 8'h33, TO - 1);
    put(9, 127, 8'h44, TO - 2);
    // Wrong row just before expiry: dropped, no restart (R4)
    put(10, 7, 8'h55, 0);
    put(9, 0,  8'h66, TO + 2);
    // Hold a write across programming: taken when busy falls (R1)
    wr_addr = AW'((12 << OW) | 9); wr_data = 8'h77; wr_valid = 1'b1;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (TO + PC + 4) @(negedge clk);

    // Randomized traffic over two rows
    for (int n = 0; n < 600; n++) begin
      wr_valid = ($urandom_range(0, 9) < 4);
      wr_addr  = AW'(($urandom_range(1, 2) << OW) | $urandom_range(0, PAGE - 1));
      wr_data  = DW'($urandom_range(0, 255));
      @(negedge clk);
    end
    wr_valid = 1'b0;
    repeat (TO + PC + 4) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule